// File: doc/BRIEF.md
# CPU Status Register Unit

This block keeps the processor status byte of a small 8-bit core. It stores five ALU condition flags (half carry, overflow, negative, zero, carry), a single transfer bit used for moving one bit between a general register and the status byte, and a global interrupt enable. The sign flag is not stored. It is always formed as negative XOR overflow, so it can never disagree with the two flags it is built from.

After each ALU operation the core presents the operands, the result, the carry out, an operation class and a mask that names which flags that operation updates. The unit works out the flags and loads only the masked ones. The interrupt enable gates a pending interrupt request. Acceptance gives a one-cycle take pulse and clears the enable. A return-from-interrupt strobe sets the enable again. The whole byte can be read and written through an I/O port.

Top module: `cpu_status_unit`

## Requirements
- R1: After synchronous reset every stored status bit is 0, so `io_rdata` reads 0x00 and `irq_take` is 0.
- R2: `io_rdata` packs, from bit 7 down to bit 0: interrupt enable, transfer bit, half carry, sign, overflow, negative, zero, carry. With `io_we` high, the register stores `io_wdata` bits 7,6,5,3,2,1,0 at the next clock edge.
- R3: The sign bit (bit 4) always equals bit 2 XOR bit 3. A value written to bit 4 is ignored.
- R4: For an addition (`alu_op`=0), half carry is the carry out of bit 3 and overflow is set when both operands have the same sign and the result has the other sign. Negative is result bit 7, zero is set for an all-zero result, and carry is `alu_cout`.
- R5: For a subtraction a−b (`alu_op`=1), half carry is the borrow into bit 4 and overflow is set when the operands differ in sign and the result's sign differs from a's. For a logic operation (`alu_op`=2), half carry and overflow are 0.
- R6: `alu_mask` bits {4,3,2,1,0} enable updates of {half carry, overflow, negative, zero, carry}. A flag whose mask bit is 0 keeps its value.
- R7: An I/O write in the same cycle as an ALU update wins: all flags take the written value.
- R8: `sw_set_ie` sets and `sw_clr_ie` clears the enable at the next edge. If both are high together, the clear wins.
- R9: While the enable is 0, a pending request never raises `irq_take`.
- R10: A request that is pending while the enable is 1 is accepted. At the next edge `irq_take` goes high for exactly one cycle and the enable goes to 0.
- R11: Acceptance beats a set-enable or return strobe in the same cycle: the enable ends at 0.
- R12: `reti` sets the enable at the next edge.
- R13: With `bst_en` high, the transfer bit takes `reg_in[bit_sel]` at the next edge.
- R14: With `bld_en` high, `reg_out` is `reg_in` with bit `bit_sel` replaced by the current transfer bit. Otherwise `reg_out` equals `reg_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | ALU result valid this cycle |
| alu_op | input | 2 | Operation class: 0 add, 1 subtract, 2 logic |
| alu_a | input | 8 | First operand |
| alu_b | input | 8 | Second operand |
| alu_res | input | 8 | ALU result |
| alu_cout | input | 1 | Carry or borrow out |
| alu_mask | input | 5 | Flag update mask {H,V,N,Z,C} |
| io_we | input | 1 | Whole-register write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Current status byte |
| sw_set_ie | input | 1 | Set interrupt enable |
| sw_clr_ie | input | 1 | Clear interrupt enable |
| reti | input | 1 | Return from interrupt |
| irq_pending | input | 1 | Pending interrupt request |
| irq_take | output | 1 | One-cycle acceptance pulse |
| bst_en | input | 1 | Copy register bit to transfer bit |
| bld_en | input | 1 | Insert transfer bit into register |
| bit_sel | input | 3 | Selected bit index |
| reg_in | input | 8 | Register operand |
| reg_out | output | 8 | Register value after bit insertion |

## Verification
The bench drives the signed boundaries 0x7F+1, 0x80−1, 0xFF+1 and 0x00−1. A swapped half-carry or overflow formula gives the wrong flags at exactly these boundaries, and a stored sign bit would show the written bit 4 instead of N XOR V. It also holds a request pending across several cycles. A take that is not registered or a clear that does not happen would then show as a take pulse longer than one cycle. Same-cycle conflicts (acceptance against set-enable, I/O write against an ALU update, set against clear) show whether the stated priority is reversed. A masked-off update also has to leave the earlier flags in place.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int MASK_W  = 5;

    // status byte bit positions
    localparam int POS_IE = 7;
    localparam int POS_TB = 6;
    localparam int POS_HC = 5;
    localparam int POS_SG = 4;
    localparam int POS_OV = 3;
    localparam int POS_NG = 2;
    localparam int POS_ZR = 1;
    localparam int POS_CY = 0;

    // mask bit positions
    localparam int MK_HC = 4;
    localparam int MK_OV = 3;
    localparam int MK_NG = 2;
    localparam int MK_ZR = 1;
    localparam int MK_CY = 0;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'd0,
        OPC_SUB   = 2'd1,
        OPC_LOGIC = 2'd2
    } op_class_e;

    typedef struct packed {
        logic hc;
        logic ov;
        logic ng;
        logic zr;
        logic cy;
    } cond_t;

    function automatic logic [DATA_W-1:0] pack_status(
        logic ie, logic tb, cond_t c);
        logic [DATA_W-1:0] v;
        v         = '0;
        v[POS_IE] = ie;
        v[POS_TB] = tb;
        v[POS_HC] = c.hc;
        v[POS_SG] = c.ng ^ c.ov;
        v[POS_OV] = c.ov;
        v[POS_NG] = c.ng;
        v[POS_ZR] = c.zr;
        v[POS_CY] = c.cy;
        return v;
    endfunction

    function automatic cond_t unpack_cond(logic [DATA_W-1:0] v);
        cond_t c;
        c.hc = v[POS_HC];
        c.ov = v[POS_OV];
        c.ng = v[POS_NG];
        c.zr = v[POS_ZR];
        c.cy = v[POS_CY];
        return c;
    endfunction
endpackage

// File: rtl/sreg_flag_calc.sv
module sreg_flag_calc
    import sreg_pkg::*;
(
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] res,
    input  logic              cout,
    output cond_t             flags
);
    localparam int MSB  = DATA_W - 1;
    localparam int NIB3 = 3;

    logic a3, b3, r3, a7, b7, r7;
    assign a3 = a[NIB3];
    assign b3 = b[NIB3];
    assign r3 = res[NIB3];
    assign a7 = a[MSB];
    assign b7 = b[MSB];
    assign r7 = res[MSB];

    always_comb begin
        flags.ng = r7;
        flags.zr = (res == '0);
        flags.cy = cout;
        case (op_class_e'(op))
            OPC_ADD: begin
                flags.hc = (a3 & b3) | (b3 & ~r3) | (~r3 & a3);
                flags.ov = (a7 & b7 & ~r7) | (~a7 & ~b7 & r7);
            end
            OPC_SUB: begin
                flags.hc = (~a3 & b3) | (b3 & r3) | (r3 & ~a3);
                flags.ov = (a7 & ~b7 & ~r7) | (~a7 & b7 & r7);
            end
            default: begin
                flags.hc = 1'b0;
                flags.ov = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sreg_ie_ctrl.sv
module sreg_ie_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic io_we,
    input  logic io_ie,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic reti,
    input  logic pending,
    output logic ie,
    output logic take
);
    logic accept;
    assign accept = pending & ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie   <= 1'b0;
            take <= 1'b0;
        end else begin
            take <= accept;
            if (accept)
                ie <= 1'b0;
            else if (io_we)
                ie <= io_ie;
            else if (sw_clr)
                ie <= 1'b0;
            else if (sw_set || reti)
                ie <= 1'b1;
        end
    end
endmodule

// File: rtl/sreg_bit_xfer.sv
module sreg_bit_xfer
    import sreg_pkg::*;
(
    input  logic [DATA_W-1:0] reg_in,
    input  logic [IDX_W-1:0]  sel,
    input  logic              tb,
    input  logic              ld_en,
    output logic              picked,
    output logic [DATA_W-1:0] reg_out
);
    assign picked = reg_in[sel];

    always_comb begin
        reg_out = reg_in;
        if (ld_en)
            reg_out[sel] = tb;
    end
endmodule

// File: rtl/cpu_status_unit.sv
module cpu_status_unit
    import sreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_valid,
    input  logic [1:0]        alu_op,
    input  logic [DATA_W-1:0] alu_a,
    input  logic [DATA_W-1:0] alu_b,
    input  logic [DATA_W-1:0] alu_res,
    input  logic              alu_cout,
    input  logic [MASK_W-1:0] alu_mask,
    input  logic              io_we,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              sw_set_ie,
    input  logic              sw_clr_ie,
    input  logic              reti,
    input  logic              irq_pending,
    output logic              irq_take,
    input  logic              bst_en,
    input  logic              bld_en,
    input  logic [IDX_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] reg_in,
    output logic [DATA_W-1:0] reg_out
);
    cond_t cond_q, cond_d, alu_flags;
    logic  tb_q, ie_w, picked;

    sreg_flag_calc u_calc (
        .op    (alu_op),
        .a     (alu_a),
        .b     (alu_b),
        .res   (alu_res),
        .cout  (alu_cout),
        .flags (alu_flags)
    );

    sreg_ie_ctrl u_ie (
        .clk     (clk),
        .rst     (rst),
        .io_we   (io_we),
        .io_ie   (io_wdata[POS_IE]),
        .sw_set  (sw_set_ie),
        .sw_clr  (sw_clr_ie),
        .reti    (reti),
        .pending (irq_pending),
        .ie      (ie_w),
        .take    (irq_take)
    );

    sreg_bit_xfer u_xfer (
        .reg_in  (reg_in),
        .sel     (bit_sel),
        .tb      (tb_q),
        .ld_en   (bld_en),
        .picked  (picked),
        .reg_out (reg_out)
    );

    // masked merge of new flags; an I/O write overrides everything
    always_comb begin
        cond_d = cond_q;
        if (io_we) begin
            cond_d = unpack_cond(io_wdata);
        end else if (alu_valid) begin
            if (alu_mask[MK_HC]) cond_d.hc = alu_flags.hc;
            if (alu_mask[MK_OV]) cond_d.ov = alu_flags.ov;
            if (alu_mask[MK_NG]) cond_d.ng = alu_flags.ng;
            if (alu_mask[MK_ZR]) cond_d.zr = alu_flags.zr;
            if (alu_mask[MK_CY]) cond_d.cy = alu_flags.cy;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= '0;
            tb_q   <= 1'b0;
        end else begin
            cond_q <= cond_d;
            if (io_we)
                tb_q <= io_wdata[POS_TB];
            else if (bst_en)
                tb_q <= picked;
        end
    end

    assign io_rdata = pack_status(ie_w, tb_q, cond_q);
endmodule

// File: rtl/cpu_status_unit_chk.sv
module cpu_status_unit_chk
    import sreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              alu_valid,
    input logic [MASK_W-1:0] alu_mask,
    input logic              io_we,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic              sw_set_ie,
    input logic              reti,
    input logic              irq_pending,
    input logic              irq_take
);
    // R3
    a_r3_sign_relation: assert property (@(posedge clk) disable iff (rst)
        io_rdata[POS_SG] == (io_rdata[POS_NG] ^ io_rdata[POS_OV]));

    // R6
    a_r6_masked_hold: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && alu_mask == '0 && !io_we) |=> $stable(io_rdata[POS_HC:POS_CY]));

    // R7
    a_r7_io_wins: assert property (@(posedge clk) disable iff (rst)
        io_we |=> (io_rdata[POS_OV:POS_CY] == $past(io_wdata[POS_OV:POS_CY])
                   && io_rdata[POS_HC] == $past(io_wdata[POS_HC])));

    // R9
    a_r9_gated: assert property (@(posedge clk) disable iff (rst)
        !io_rdata[POS_IE] |=> !irq_take);

    // R10
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !irq_take);

    // R10
    a_r10_clear_on_take: assert property (@(posedge clk) disable iff (rst)
        irq_take |-> !io_rdata[POS_IE]);

    // R11
    a_r11_accept_beats_set: assert property (@(posedge clk) disable iff (rst)
        (irq_pending && io_rdata[POS_IE] && (sw_set_ie || reti)) |=> !io_rdata[POS_IE]);

    // R12
    a_r12_reti_sets: assert property (@(posedge clk) disable iff (rst)
        (reti && !io_we && !(irq_pending && io_rdata[POS_IE])) |=> io_rdata[POS_IE]);
endmodule

bind cpu_status_unit cpu_status_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .alu_valid   (alu_valid),
    .alu_mask    (alu_mask),
    .io_we       (io_we),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .sw_set_ie   (sw_set_ie),
    .reti        (reti),
    .irq_pending (irq_pending),
    .irq_take    (irq_take)
);

// File: tb/cpu_status_unit_tb_top.sv
module cpu_status_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       alu_valid;
    logic [1:0] alu_op;
    logic [7:0] alu_a, alu_b, alu_res;
    logic       alu_cout;
    logic [4:0] alu_mask;
    logic       io_we;
    logic [7:0] io_wdata, io_rdata;
    logic       sw_set_ie, sw_clr_ie, reti, irq_pending, irq_take;
    logic       bst_en, bld_en;
    logic [2:0] bit_sel;
    logic [7:0] reg_in, reg_out;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    cpu_status_unit dut_i (.*);

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        alu_valid = 0; alu_op = 0; alu_a = 0; alu_b = 0; alu_res = 0;
        alu_cout = 0; alu_mask = 0; io_we = 0; io_wdata = 0;
        sw_set_ie = 0; sw_clr_ie = 0; reti = 0; irq_pending = 0;
        bst_en = 0; bld_en = 0; bit_sel = 0; reg_in = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        @(negedge clk);
        idle();
    endtask

    task automatic io_write(input logic [7:0] v);
        io_we = 1; io_wdata = v;
        step();
    endtask

    task automatic alu(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] r, input logic c, input logic [4:0] m);
        alu_valid = 1; alu_op = op; alu_a = a; alu_b = b; alu_res = r;
        alu_cout = c; alu_mask = m;
        step();
    endtask

    task automatic t_reset();
        check("R1 rdata", io_rdata, 8'h00);
        check("R1 take", {7'd0, irq_take}, 8'h00);
    endtask

    task automatic t_io();
        io_write(8'hFF);
        check("R2/R3 write FF", io_rdata, 8'hEF);
        io_write(8'h04);
        check("R3 N only", io_rdata, 8'h14);
        io_write(8'h10);
        check("R3 bit4 ignored", io_rdata, 8'h00);
        io_write(8'h62);
        check("R2 T,H,Z", io_rdata, 8'h62);
        io_write(8'h00);
    endtask

    task automatic t_add();
        alu(2'd0, 8'h0F, 8'h01, 8'h10, 1'b0, 5'h1F);
        check("R4 0F+01", io_rdata, 8'h20);
        alu(2'd0, 8'h7F, 8'h01, 8'h80, 1'b0, 5'h1F);
        check("R4 7F+01", io_rdata, 8'h2C);
        alu(2'd0, 8'hFF, 8'h01, 8'h00, 1'b1, 5'h1F);
        check("R4 FF+01", io_rdata, 8'h23);
    endtask

    task automatic t_sub();
        alu(2'd1, 8'h10, 8'h01, 8'h0F, 1'b0, 5'h1F);
        check("R5 10-01", io_rdata, 8'h20);
        alu(2'd1, 8'h80, 8'h01, 8'h7F, 1'b0, 5'h1F);
        check("R5 80-01", io_rdata, 8'h38);
        alu(2'd1, 8'h00, 8'h01, 8'hFF, 1'b1, 5'h1F);
        check("R5 00-01", io_rdata, 8'h35);
        alu(2'd2, 8'hF0, 8'h0F, 8'h00, 1'b0, 5'h1F);
        check("R5 logic", io_rdata, 8'h02);
    endtask

    task automatic t_mask();
        io_write(8'h00);
        alu(2'd0, 8'h00, 8'h00, 8'h00, 1'b0, 5'b00010);
        check("R6 Z only", io_rdata, 8'h02);
        alu(2'd0, 8'hFF, 8'h01, 8'h00, 1'b1, 5'b00001);
        check("R6 C only", io_rdata, 8'h03);
        alu(2'd0, 8'h7F, 8'h01, 8'h80, 1'b0, 5'b00000);
        check("R6 none", io_rdata, 8'h03);
    endtask

    task automatic t_io_prio();
        io_we = 1; io_wdata = 8'h01;
        alu_valid = 1; alu_op = 0; alu_a = 8'h00; alu_b = 8'h00; alu_res = 8'h00;
        alu_mask = 5'h1F;
        step();
        check("R7 io over alu", io_rdata, 8'h01);
        io_write(8'h00);
    endtask

    task automatic t_sw();
        sw_set_ie = 1; step();
        check("R8 set", io_rdata, 8'h80);
        sw_clr_ie = 1; step();
        check("R8 clr", io_rdata, 8'h00);
        sw_set_ie = 1; step();
        sw_set_ie = 1; sw_clr_ie = 1; step();
        check("R8 clr wins", io_rdata, 8'h00);
    endtask

    task automatic t_gate();
        logic seen = 0;
        for (int i = 0; i < 4; i++) begin
            irq_pending = 1; step();
            if (irq_take) seen = 1;
        end
        check("R9 no take while disabled", {7'd0, seen}, 8'h00);
    endtask

    task automatic t_accept();
        sw_set_ie = 1; step();
        irq_pending = 1; step();
        check("R10 take high", {7'd0, irq_take}, 8'h01);
        check("R10 ie cleared", {7'd0, io_rdata[7]}, 8'h00);
        irq_pending = 1; step();
        check("R10 take one cycle", {7'd0, irq_take}, 8'h00);
    endtask

    task automatic t_accept_vs_set();
        sw_set_ie = 1; step();
        irq_pending = 1; sw_set_ie = 1; reti = 1; step();
        check("R11 take", {7'd0, irq_take}, 8'h01);
        check("R11 ie stays clear", {7'd0, io_rdata[7]}, 8'h00);
    endtask

    task automatic t_reti();
        reti = 1; step();
        check("R12 reti sets ie", {7'd0, io_rdata[7]}, 8'h01);
        sw_clr_ie = 1; step();
    endtask

    task automatic t_bits();
        bst_en = 1; reg_in = 8'hA5; bit_sel = 3'd2; step();
        check("R13 store bit2", {7'd0, io_rdata[6]}, 8'h01);
        #1;
        bld_en = 1; reg_in = 8'h00; bit_sel = 3'd7; #1;
        check("R14 load into bit7", reg_out, 8'h80);
        bld_en = 0; #1;
        check("R14 no load passthrough", reg_out, 8'h00);
        bst_en = 1; reg_in = 8'hA5; bit_sel = 3'd1; step();
        check("R13 store bit1", {7'd0, io_rdata[6]}, 8'h00);
        bld_en = 1; reg_in = 8'hFF; bit_sel = 3'd0; #1;
        check("R14 load into bit0", reg_out, 8'hFE);
        idle();
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_io();
        t_add();
        t_sub();
        t_mask();
        t_io_prio();
        t_sw();
        t_gate();
        t_accept();
        t_accept_vs_set();
        t_reti();
        t_bits();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end
endmodule